// File: doc/BRIEF.md
# Serial Configuration Register Port

This block is the configuration port of a data-converter controller. A host acts as the master on a slow serial bus, and the block is always the slave. The port lets the host write and read a small file of 8-bit registers. The fields held in that file drive the rest of the chip: a clock divide code, an output drive mode, a data coding format, and coarse offset and gain words. The link runs half duplex. Every transaction opens with an instruction byte that carries a read/write flag and a 7-bit register address. One or more data bytes follow until chip select is released.

The serial clock, chip select and data input are brought into the system clock domain through two-flop synchronisers. All decoding is done on the synchronised edges, so the system clock must be several times faster than the serial clock. Two bits of the port configuration register choose the bit order and the pin mode. In 3-wire mode the read data returns on the shared data line. In 4-wire mode it returns on a separate output, which allows several slaves to share the bus. During a burst the address moves by one register per byte. It stops moving once it reaches the address held in the burst end register.

Top module: `cfgspi_slave`

## Requirements
- R1: After reset every configuration output reads zero, both output enables are low, the port is in 3-wire MSB-first mode and the burst end address is 0x00.
- R2: A transaction begins with chip select low and an instruction byte. Bit 7 of that byte is the read/write flag, where 1 means read, and bits 6:0 are the address. Data bytes follow. In the default MSB-first order, bit 7 of each byte is shifted first. Data is sampled on rising serial clock edges.
- R3: When bit 6 of register 0x00 is 1, every byte, the instruction byte included, is shifted LSB first. For the instruction byte this means address bit 0 comes first and the read/write flag comes last.
- R4: After each data byte the address steps by +1 in MSB-first order and by -1 in LSB-first order, wrapping modulo 128.
- R5: Once the current address equals bits 6:0 of register 0x02, the address no longer steps, and every further byte of the burst goes to that same address.
- R6: In 3-wire mode (bit 7 of register 0x00 is 0), read data is launched on falling serial clock edges onto sdio_o with sdio_oe high and sdo_oe low, in the selected bit order.
- R7: In 4-wire mode (bit 7 of register 0x00 is 1), read data appears on sdo with sdo_oe high and sdio_oe low.
- R8: Register 0x08 reads CHIP_ID and register 0x09 reads CHIP_REV. Writes to either register have no effect.
- R9: Writes to unmapped addresses are ignored, and reads from them return 0x00. The unused bits of mapped registers read as 0.
- R10: Raising chip select part way through a byte discards that byte and writes nothing. The next transaction starts again with an instruction byte.
- R11: Register 0x73 bits 7:5 drive out_mode, with 000 for pin control, 001 for low-drive differential and 010 for high-drive differential. Bits 2:0 of 0x73 drive data_fmt, bits 1:0 of 0x72 drive clk_div, 0x20 drives offset_coarse and 0x22 drives gain_coarse. Each output changes only when its register is written.
- R12: Within four system clock cycles of chip select going high, both output enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idle low |
| csn | input | 1 | Active-low chip select |
| sdio_i | input | 1 | Serial data in (shared line input) |
| sdio_o | output | 1 | Read data onto the shared line |
| sdio_oe | output | 1 | Drive enable for the shared line (3-wire mode) |
| sdo | output | 1 | Read data on the separate output (4-wire mode) |
| sdo_oe | output | 1 | Drive enable for the separate output |
| clk_div | output | 2 | Clock divide code |
| out_mode | output | 3 | Output drive mode code |
| data_fmt | output | 3 | Output data coding code |
| offset_coarse | output | 8 | Coarse offset word |
| gain_coarse | output | 8 | Coarse gain word |

## Verification
On the same synchronised rising edge, the eighth bit completes a byte, that byte is committed to the current address, and the address is compared with the burst end value to choose the next address. Bursts are therefore started one register below the burst end value and run for several bytes, so that the commit and the stop fall together. The bench then checks that the byte after the stop lands on the end address and that its neighbour is untouched. A second pairing is a chip select release against a partial byte: a burst is cut after five bits, and the bench checks that no output moved and that a following transaction decodes normally.

// File: rtl/cfgspi_pkg.sv
package cfgspi_pkg;
  localparam int BYTE_W  = 8;
  localparam int ADDR_W  = BYTE_W - 1;
  localparam int CDIV_W  = 2;
  localparam int OMODE_W = 3;
  localparam int FMT_W   = 3;
  localparam int SYNC_N  = 2;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [ADDR_W-1:0] addr_t;

  localparam addr_t A_PORT  = 7'h00;
  localparam addr_t A_BEND  = 7'h02;
  localparam addr_t A_ID    = 7'h08;
  localparam addr_t A_REV   = 7'h09;
  localparam addr_t A_OFS   = 7'h20;
  localparam addr_t A_GAIN  = 7'h22;
  localparam addr_t A_CDIV  = 7'h72;
  localparam addr_t A_OMODE = 7'h73;
endpackage

// File: rtl/cfgspi_sync.sv
module cfgspi_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[g] <= RST_VAL;
          else        stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/cfgspi_serial.sv
module cfgspi_serial
  import cfgspi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sclk_s,
  input  logic  csn_s,
  input  logic  sdi_s,
  input  logic  lsb_first,
  input  addr_t burst_end,
  input  byte_t rdata,
  output addr_t cur_addr,
  output logic  we,
  output addr_t waddr,
  output byte_t wdata,
  output logic  out_bit,
  output logic  drive
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic          sclk_d_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          instr_q, instr_n;
  logic          rw_q, rw_n;
  addr_t         addr_q, addr_n;
  byte_t         sr_q, sr_n;
  byte_t         txb_q, txb_n;
  logic          ld_q, ld_n;
  logic          out_q, out_n;
  logic          drv_q, drv_n;
  logic          we_q, we_n;
  addr_t         wa_q, wa_n;
  byte_t         wd_q, wd_n;

  logic          rise, fall, last;
  byte_t         shifted;
  addr_t         step_addr;
  logic [CW-1:0] bit_sel;

  always_comb begin
    rise      = sclk_s & ~sclk_d_q & ~csn_s;
    fall      = ~sclk_s & sclk_d_q & ~csn_s;
    last      = (cnt_q == LAST);
    shifted   = lsb_first ? {sdi_s, sr_q[BYTE_W-1:1]} : {sr_q[BYTE_W-2:0], sdi_s};
    bit_sel   = lsb_first ? cnt_q : (LAST - cnt_q);
    if (addr_q == burst_end)  step_addr = addr_q;
    else if (lsb_first)       step_addr = addr_q - addr_t'(1);
    else                      step_addr = addr_q + addr_t'(1);
  end

  always_comb begin
    cnt_n   = cnt_q;
    instr_n = instr_q;
    rw_n    = rw_q;
    addr_n  = addr_q;
    sr_n    = sr_q;
    txb_n   = txb_q;
    ld_n    = 1'b0;
    out_n   = out_q;
    drv_n   = drv_q;
    we_n    = 1'b0;
    wa_n    = wa_q;
    wd_n    = wd_q;
    if (ld_q) txb_n = rdata;
    if (csn_s) begin
      cnt_n   = '0;
      instr_n = 1'b0;
      drv_n   = 1'b0;
    end else begin
      if (rise) begin
        sr_n  = shifted;
        cnt_n = last ? '0 : cnt_q + CW'(1);
        if (last) begin
          if (!instr_q) begin
            instr_n = 1'b1;
            rw_n    = shifted[BYTE_W-1];
            addr_n  = shifted[ADDR_W-1:0];
            ld_n    = shifted[BYTE_W-1];
            drv_n   = shifted[BYTE_W-1];
          end else begin
            we_n   = ~rw_q;
            wa_n   = addr_q;
            wd_n   = shifted;
            addr_n = step_addr;
            ld_n   = rw_q;
          end
        end
      end
      if (fall && drv_q) out_n = txb_q[bit_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d_q <= 1'b0;
      cnt_q    <= '0;
      instr_q  <= 1'b0;
      rw_q     <= 1'b0;
      addr_q   <= '0;
      sr_q     <= '0;
      txb_q    <= '0;
      ld_q     <= 1'b0;
      out_q    <= 1'b0;
      drv_q    <= 1'b0;
      we_q     <= 1'b0;
      wa_q     <= '0;
      wd_q     <= '0;
    end else begin
      sclk_d_q <= sclk_s;
      cnt_q    <= cnt_n;
      instr_q  <= instr_n;
      rw_q     <= rw_n;
      addr_q   <= addr_n;
      sr_q     <= sr_n;
      txb_q    <= txb_n;
      ld_q     <= ld_n;
      out_q    <= out_n;
      drv_q    <= drv_n;
      we_q     <= we_n;
      wa_q     <= wa_n;
      wd_q     <= wd_n;
    end
  end

  assign cur_addr = addr_q;
  assign we       = we_q;
  assign waddr    = wa_q;
  assign wdata    = wd_q;
  assign out_bit  = out_q;
  assign drive    = drv_q;
endmodule

// File: rtl/cfgspi_regs.sv
module cfgspi_regs
  import cfgspi_pkg::*;
#(
  parameter byte_t CHIP_ID  = 8'h5C,
  parameter byte_t CHIP_REV = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we,
  input  addr_t              waddr,
  input  byte_t              wdata,
  input  addr_t              raddr,
  output byte_t              rdata,
  output logic               wire4,
  output logic               lsb_first,
  output addr_t              burst_end,
  output logic [CDIV_W-1:0]  clk_div,
  output logic [OMODE_W-1:0] out_mode,
  output logic [FMT_W-1:0]   data_fmt,
  output byte_t              offset_coarse,
  output byte_t              gain_coarse
);
  logic [1:0]         port_q, port_n;
  addr_t              bend_q, bend_n;
  byte_t              ofs_q, ofs_n;
  byte_t              gain_q, gain_n;
  logic [CDIV_W-1:0]  cdiv_q, cdiv_n;
  logic [OMODE_W-1:0] omode_q, omode_n;
  logic [FMT_W-1:0]   fmt_q, fmt_n;

  always_comb begin
    port_n  = port_q;
    bend_n  = bend_q;
    ofs_n   = ofs_q;
    gain_n  = gain_q;
    cdiv_n  = cdiv_q;
    omode_n = omode_q;
    fmt_n   = fmt_q;
    if (we) begin
      case (waddr)
        A_PORT:  port_n  = wdata[7:6];
        A_BEND:  bend_n  = wdata[ADDR_W-1:0];
        A_OFS:   ofs_n   = wdata;
        A_GAIN:  gain_n  = wdata;
        A_CDIV:  cdiv_n  = wdata[CDIV_W-1:0];
        A_OMODE: begin
          omode_n = wdata[7:5];
          fmt_n   = wdata[FMT_W-1:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      port_q  <= '0;
      bend_q  <= '0;
      ofs_q   <= '0;
      gain_q  <= '0;
      cdiv_q  <= '0;
      omode_q <= '0;
      fmt_q   <= '0;
    end else begin
      port_q  <= port_n;
      bend_q  <= bend_n;
      ofs_q   <= ofs_n;
      gain_q  <= gain_n;
      cdiv_q  <= cdiv_n;
      omode_q <= omode_n;
      fmt_q   <= fmt_n;
    end
  end

  always_comb begin
    case (raddr)
      A_PORT:  rdata = {port_q, 6'b0};
      A_BEND:  rdata = {1'b0, bend_q};
      A_ID:    rdata = CHIP_ID;
      A_REV:   rdata = CHIP_REV;
      A_OFS:   rdata = ofs_q;
      A_GAIN:  rdata = gain_q;
      A_CDIV:  rdata = {{(BYTE_W-CDIV_W){1'b0}}, cdiv_q};
      A_OMODE: rdata = {omode_q, 2'b0, fmt_q};
      default: rdata = '0;
    endcase
  end

  assign wire4         = port_q[1];
  assign lsb_first     = port_q[0];
  assign burst_end     = bend_q;
  assign clk_div       = cdiv_q;
  assign out_mode      = omode_q;
  assign data_fmt      = fmt_q;
  assign offset_coarse = ofs_q;
  assign gain_coarse   = gain_q;
endmodule

// File: rtl/cfgspi_slave.sv
module cfgspi_slave
  import cfgspi_pkg::*;
#(
  parameter byte_t CHIP_ID  = 8'h5C,
  parameter byte_t CHIP_REV = 8'h01
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sclk,
  input  logic               csn,
  input  logic               sdio_i,
  output logic               sdio_o,
  output logic               sdio_oe,
  output logic               sdo,
  output logic               sdo_oe,
  output logic [CDIV_W-1:0]  clk_div,
  output logic [OMODE_W-1:0] out_mode,
  output logic [FMT_W-1:0]   data_fmt,
  output byte_t              offset_coarse,
  output byte_t              gain_coarse
);
  logic [2:0] pins_s;
  logic       wire4, lsb_first;
  addr_t      burst_end, cur_addr, reg_waddr;
  byte_t      rdata, reg_wdata;
  logic       reg_we, out_bit, drive;

  cfgspi_sync #(.W(3), .STAGES(SYNC_N), .RST_VAL(3'b010)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({sclk, csn, sdio_i}),
    .q     (pins_s)
  );

  cfgspi_serial u_serial (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (pins_s[2]),
    .csn_s     (pins_s[1]),
    .sdi_s     (pins_s[0]),
    .lsb_first (lsb_first),
    .burst_end (burst_end),
    .rdata     (rdata),
    .cur_addr  (cur_addr),
    .we        (reg_we),
    .waddr     (reg_waddr),
    .wdata     (reg_wdata),
    .out_bit   (out_bit),
    .drive     (drive)
  );

  cfgspi_regs #(.CHIP_ID(CHIP_ID), .CHIP_REV(CHIP_REV)) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .we            (reg_we),
    .waddr         (reg_waddr),
    .wdata         (reg_wdata),
    .raddr         (cur_addr),
    .rdata         (rdata),
    .wire4         (wire4),
    .lsb_first     (lsb_first),
    .burst_end     (burst_end),
    .clk_div       (clk_div),
    .out_mode      (out_mode),
    .data_fmt      (data_fmt),
    .offset_coarse (offset_coarse),
    .gain_coarse   (gain_coarse)
  );

  assign sdo     = out_bit;
  assign sdio_o  = out_bit;
  assign sdo_oe  = drive & wire4;
  assign sdio_oe = drive & ~wire4;
endmodule

// File: rtl/cfgspi_chk.sv
module cfgspi_chk
  import cfgspi_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               csn,
  input logic               sdo_oe,
  input logic               sdio_oe,
  input logic               wire4,
  input logic               we,
  input addr_t              waddr,
  input logic [OMODE_W-1:0] out_mode,
  input byte_t              gain_coarse,
  input logic [CDIV_W-1:0]  clk_div
);
  assert_oe_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sdo_oe && sdio_oe));

  assert_sdo_mode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> wire4);

  assert_sdio_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sdio_oe |-> !wire4);

  assert_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (csn && $past(csn) && $past(csn, 2) && $past(csn, 3)) |-> (!sdo_oe && !sdio_oe));

  assert_omode_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && waddr == A_OMODE) |=> $stable(out_mode));

  assert_gain_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && waddr == A_GAIN) |=> $stable(gain_coarse));

  assert_cdiv_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && waddr == A_CDIV) |=> $stable(clk_div));
endmodule

bind cfgspi_slave cfgspi_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csn         (csn),
  .sdo_oe      (sdo_oe),
  .sdio_oe     (sdio_oe),
  .wire4       (wire4),
  .we          (reg_we),
  .waddr       (reg_waddr),
  .out_mode    (out_mode),
  .gain_coarse (gain_coarse),
  .clk_div     (clk_div)
);

// File: tb/sim_cfgspi_slave.sv
`timescale 1ns/1ps
module sim_cfgspi_slave;
  localparam int HP = 6;
  localparam logic [7:0] ID  = 8'h5C;
  localparam logic [7:0] REV = 8'h01;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, sdio_i = 1'b0;
  logic sdio_o, sdio_oe, sdo, sdo_oe;
  logic [1:0] clk_div;
  logic [2:0] out_mode, data_fmt;
  logic [7:0] offset_coarse, gain_coarse;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] mdl [128];
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always #5 clk = ~clk;

  cfgspi_slave u0 (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .csn(csn), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo(sdo), .sdo_oe(sdo_oe),
    .clk_div(clk_div), .out_mode(out_mode), .data_fmt(data_fmt),
    .offset_coarse(offset_coarse), .gain_coarse(gain_coarse)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic void mwrite(input logic [6:0] a, input logic [7:0] d);
    case (a)
      7'h00: mdl[a] = {d[7:6], 6'b0};
      7'h02: mdl[a] = {1'b0, d[6:0]};
      7'h20, 7'h22: mdl[a] = d;
      7'h72: mdl[a] = {6'b0, d[1:0]};
      7'h73: mdl[a] = {d[7:5], 2'b0, d[2:0]};
      default: ;
    endcase
  endfunction

  function automatic logic [6:0] mstep(input logic [6:0] a, input bit lsb);
    if (a == mdl[2][6:0]) return a;
    return lsb ? a - 7'd1 : a + 7'd1;
  endfunction

  function automatic string rtag(input logic [6:0] a, input bit w4);
    if (a == 7'h08 || a == 7'h09) return "R8";
    if (!(a inside {7'h00, 7'h02, 7'h20, 7'h22, 7'h72, 7'h73})) return "R9";
    return w4 ? "R7" : "R6";
  endfunction

  task automatic xbyte(input logic [7:0] tx, input bit lsb, input bit w4,
                       input bit rd, output logic [7:0] rx);
    rx = '0;
    for (int i = 0; i < 8; i++) begin
      int idx = lsb ? i : 7 - i;
      sdio_i = tx[idx];
      wt(HP);
      rx[idx] = w4 ? sdo : sdio_o;
      if (rd && i == 0)
        check(w4 ? "R7 oe" : "R6 oe", {30'd0, sdo_oe, sdio_oe}, w4 ? 32'd2 : 32'd1);
      sclk = 1'b1;
      wt(HP);
      sclk = 1'b0;
    end
  endtask

  task automatic txn(input bit rw, input logic [6:0] a, input int n);
    bit lsb = mdl[0][6];
    bit w4 = mdl[0][7];
    logic [7:0] dummy;
    logic [6:0] cur = a;
    csn = 1'b0;
    wt(HP);
    xbyte({rw, a}, lsb, w4, 1'b0, dummy);
    for (int k = 0; k < n; k++) xbyte(wbuf[k], lsb, w4, rw, rbuf[k]);
    wt(HP);
    csn = 1'b1;
    wt(4 * HP);
    check("R12 oe released", {30'd0, sdo_oe, sdio_oe}, 32'd0);
    for (int k = 0; k < n; k++) begin
      if (rw) check(rtag(cur, w4), {24'd0, rbuf[k]}, {24'd0, mdl[cur]});
      else mwrite(cur, wbuf[k]);
      cur = mstep(cur, lsb);
    end
  endtask

  task automatic chk_outs(input string tag);
    check({tag, " clk_div"},  {30'd0, clk_div},       {30'd0, mdl[7'h72][1:0]});
    check({tag, " out_mode"}, {29'd0, out_mode},      {29'd0, mdl[7'h73][7:5]});
    check({tag, " data_fmt"}, {29'd0, data_fmt},      {29'd0, mdl[7'h73][2:0]});
    check({tag, " offset"},   {24'd0, offset_coarse}, {24'd0, mdl[7'h20]});
    check({tag, " gain"},     {24'd0, gain_coarse},   {24'd0, gain_coarse === mdl[7'h22] ? gain_coarse : mdl[7'h22]});
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R10 act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] dummy;
    logic [6:0] starts [10] = '{7'h20, 7'h21, 7'h22, 7'h70, 7'h71, 7'h72, 7'h73, 7'h08, 7'h09, 7'h40};
    void'($urandom(32'd20240607));
    for (int i = 0; i < 128; i++) mdl[i] = '0;
    mdl[8] = ID;
    mdl[9] = REV;
    wt(4);
    rst_n = 1'b1;
    wt(4);

    // R1 reset state
    check("R1 oe", {30'd0, sdo_oe, sdio_oe}, 32'd0);
    chk_outs("R1");

    // R2 R11 single write to 0x73
    wbuf[0] = 8'h45;
    txn(1'b0, 7'h73, 1);
    check("R11 out_mode high drive", {29'd0, out_mode}, 32'd2);
    chk_outs("R2");

    // R4 R9 MSB burst over a reserved hole
    wbuf[0] = 8'hA1; wbuf[1] = 8'h77; wbuf[2] = 8'h3C;
    txn(1'b0, 7'h20, 3);
    chk_outs("R4");
    txn(1'b1, 7'h20, 3);
    txn(1'b1, 7'h00, 1);

    // R8 identification values, write ignored
    txn(1'b1, 7'h08, 2);
    wbuf[0] = 8'hFF; wbuf[1] = 8'hFF;
    txn(1'b0, 7'h08, 2);
    txn(1'b1, 7'h08, 2);

    // R5 burst end: commit and stop coincide
    wbuf[0] = 8'h21;
    txn(1'b0, 7'h02, 1);
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    txn(1'b0, 7'h20, 3);
    check("R5 gain untouched", {24'd0, gain_coarse}, 32'h3C);
    chk_outs("R5");

    // R10 abort mid byte
    csn = 1'b0;
    wt(HP);
    xbyte({1'b0, 7'h22}, 1'b0, 1'b0, 1'b0, dummy);
    for (int i = 0; i < 5; i++) begin
      sdio_i = 1'b1; wt(HP); sclk = 1'b1; wt(HP); sclk = 1'b0;
    end
    wt(HP);
    csn = 1'b1;
    wt(4 * HP);
    check("R10 gain after abort", {24'd0, gain_coarse}, 32'h3C);
    wbuf[0] = 8'h5A;
    txn(1'b0, 7'h22, 1);
    check("R10 write after abort", {24'd0, gain_coarse}, 32'h5A);

    // R7 four-wire readback
    wbuf[0] = 8'h80;
    txn(1'b0, 7'h00, 1);
    txn(1'b1, 7'h73, 1);
    txn(1'b1, 7'h20, 2);

    // R3 LSB first, R4 decrementing burst
    wbuf[0] = 8'h40;
    txn(1'b0, 7'h00, 1);
    wbuf[0] = 8'h2B; wbuf[1] = 8'h03;
    txn(1'b0, 7'h73, 2);
    check("R3 data_fmt", {29'd0, data_fmt}, 32'd3);
    check("R3 clk_div", {30'd0, clk_div}, 32'd3);
    chk_outs("R3");
    txn(1'b1, 7'h73, 2);

    // random phase
    for (int t = 0; t < 40; t++) begin
      if (t % 10 == 0) begin
        wbuf[0] = {2'($urandom()), 6'd0};
        txn(1'b0, 7'h00, 1);
      end
      for (int k = 0; k < 4; k++) wbuf[k] = 8'($urandom());
      txn(1'($urandom()), starts[$urandom() % 10], 1 + int'($urandom() % 4));
      chk_outs(mdl[0][6] ? "R3" : "R2");
    end

    summary();
    $finish;
  end
endmodule